// File: doc/BRIEF.md
# CAN Transmit Pin Test Control

This block sits between a CAN protocol core and the transceiver pins. In normal operation it registers the core's transmit bit onto the transmit pin at each end-of-bit-time strobe. It also passes the synchronized receive pin back to the core. A small control register switches the transmit pin to one of three test sources: the sample-point strobe, a forced dominant level or a forced recessive level. The same register enables an internal loop-back path. In loop-back, the core's transmit bit is returned as its receive bit, and the external receive level stays visible in a read-only status bit.

Bus arbitration, bit timing and frame handling stay outside the block. Software writes the control register through a single-cycle write strobe. It reads the register back combinationally. Register layout: bit 0 is the loop-back enable, bits 2:1 are the transmit mode, bit 3 is the read-only receive status, and bits 7:4 are reserved.

Top module: `can_pin_test`

## Requirements
- R1: After reset, the transmit mode is 00 and loop-back is off. The transmit pin is 1 (recessive), the core receive output is 1, and the register reads 0x08 while the receive status is recessive.
- R2: In mode 00, the transmit pin takes the core transmit bit one clock after an edge where the end-of-bit-time strobe is high. Otherwise the pin holds its value.
- R3: In mode 01, the transmit pin equals the sample-point strobe of the previous cycle.
- R4: Mode 10 drives the transmit pin to 0 (dominant) from the next clock. Mode 11 drives it to 1 (recessive) from the next clock.
- R5: Register bit 3 shows the receive pin level (0 dominant, 1 recessive) two clock edges after the pin changes.
- R6: With loop-back on (bit 0 = 1), the core receive output follows the core transmit bit without delay. Bit 3 still shows the external receive pin.
- R7: With loop-back off, the core receive output is the synchronized receive pin, the same value that bit 3 shows.
- R8: Bits 2:0 read back as written. Writes to bits 7:4 and bit 3 have no effect, and bits 7:4 read 0.
- R9: On a switch from a forced mode back to mode 00, the transmit pin keeps its last level until the next end-of-bit-time strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| core_tx_i | input | 1 | Transmit bit from the protocol core |
| sample_pt_i | input | 1 | Sample-point strobe |
| bit_end_i | input | 1 | End-of-bit-time strobe |
| can_rx_i | input | 1 | Raw receive pin |
| can_tx_o | output | 1 | Driven transmit pin |
| core_rx_o | output | 1 | Receive bit handed to the core |

## Verification
A wrong transmit mode shows on the transmit pin one clock after the stimulus that should have set the pin: a forced level is missing, a strobe is not mirrored, or a load happens without an end-of-bit strobe. A stuck or mis-staged synchronizer shows up as a status bit that changes after one edge or after three, where two are expected. A wrong loop-back select appears at once on the core receive output, because that output differs from the status bit whenever the transmit and receive levels disagree.

// File: rtl/can_pin_pkg.sv
package can_pin_pkg;
  typedef enum logic [1:0] {
    TX_CORE   = 2'b00,
    TX_SAMPLE = 2'b01,
    TX_DOM    = 2'b10,
    TX_REC    = 2'b11
  } tx_mode_e;

  localparam int LOOP_BIT = 0;
  localparam int MODE_LSB = 1;
  localparam int RXST_BIT = 3;
  localparam int USED_W   = 4;

  typedef struct packed {
    tx_mode_e mode;
    logic     loop;
  } pin_ctrl_t;
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/can_pin_regs.sv
module can_pin_regs
  import can_pin_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rx_stat_i,
  output pin_ctrl_t        ctrl_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int PAD_W = REG_W - USED_W;

  pin_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{mode: TX_CORE, loop: 1'b0};
    end else if (we_i) begin
      ctrl_q.mode <= tx_mode_e'(wdata_i[MODE_LSB +: 2]);
      ctrl_q.loop <= wdata_i[LOOP_BIT];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {{PAD_W{1'b0}}, rx_stat_i, ctrl_q.mode, ctrl_q.loop};

  p_wr_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[MODE_LSB +: 2] == $past(wdata_i[MODE_LSB +: 2]));
  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o[RXST_BIT-1:0]));
endmodule

// File: rtl/can_tx_sel.sv
module can_tx_sel
  import can_pin_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tx_mode_e mode_i,
  input  logic     core_tx_i,
  input  logic     sample_pt_i,
  input  logic     bit_end_i,
  output logic     tx_o
);
  logic tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    unique case (mode_i)
      TX_CORE:   if (bit_end_i) tx_d = core_tx_i;
      TX_SAMPLE: tx_d = sample_pt_i;
      TX_DOM:    tx_d = 1'b0;
      TX_REC:    tx_d = 1'b1;
      default:   tx_d = tx_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b1;
    else         tx_q <= tx_d;
  end

  assign tx_o = tx_q;

  p_core_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TX_CORE && !bit_end_i) |=> $stable(tx_o));
  p_core_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TX_CORE && bit_end_i) |=> tx_o == $past(core_tx_i));
  p_monitor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TX_SAMPLE) |=> tx_o == $past(sample_pt_i));
  p_force_dom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TX_DOM) |=> !tx_o);
  p_force_rec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TX_REC) |=> tx_o);
endmodule

// File: rtl/can_pin_test.sv
module can_pin_test
  import can_pin_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             core_tx_i,
  input  logic             sample_pt_i,
  input  logic             bit_end_i,
  input  logic             can_rx_i,
  output logic             can_tx_o,
  output logic             core_rx_o
);
  pin_ctrl_t ctrl;
  logic      rx_sync;

  can_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (can_rx_i),
    .q_o   (rx_sync)
  );

  can_pin_regs #(.REG_W(REG_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rx_stat_i(rx_sync),
    .ctrl_o   (ctrl),
    .rdata_o  (reg_rdata_o)
  );

  can_tx_sel u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (ctrl.mode),
    .core_tx_i  (core_tx_i),
    .sample_pt_i(sample_pt_i),
    .bit_end_i  (bit_end_i),
    .tx_o       (can_tx_o)
  );

  // loop-back returns the core's own bit; status keeps the external pin
  assign core_rx_o = ctrl.loop ? core_tx_i : rx_sync;

  p_rx_normal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[LOOP_BIT] |-> core_rx_o == reg_rdata_o[RXST_BIT]);
  p_rx_loop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[LOOP_BIT] |-> core_rx_o == core_tx_i);
endmodule

// File: tb/sim_can_pin_test.sv
module sim_can_pin_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;
  localparam int NVEC       = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       core_tx = 1'b1, samp = 1'b0, bend = 1'b0, rx = 1'b1;
  logic       tx, core_rx;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_pin_test u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .core_tx_i(core_tx), .sample_pt_i(samp),
    .bit_end_i(bend), .can_rx_i(rx), .can_tx_o(tx), .core_rx_o(core_rx)
  );

  // {we, wdata[7:0], core_tx, sample_pt, bit_end, expected tx}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 4'b0001}, {1'b0, 8'h00, 4'b0010},
    {1'b0, 8'h00, 4'b1000}, {1'b0, 8'h00, 4'b1011},
    {1'b1, 8'h02, 4'b0010}, {1'b0, 8'h00, 4'b0101},
    {1'b0, 8'h00, 4'b0000}, {1'b0, 8'h00, 4'b0111},
    {1'b1, 8'h04, 4'b0000}, {1'b0, 8'h00, 4'b1110},
    {1'b1, 8'h06, 4'b1000}, {1'b0, 8'h00, 4'b0011},
    {1'b1, 8'h00, 4'b0001}, {1'b0, 8'h00, 4'b0001},
    {1'b0, 8'h00, 4'b0010}, {1'b1, 8'h04, 4'b1000},
    {1'b0, 8'h00, 4'b0000}, {1'b1, 8'h00, 4'b0000},
    {1'b0, 8'h00, 4'b1000}, {1'b0, 8'h00, 4'b1011}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0; wdata = 8'h00;
  endtask

  initial begin : wdog
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx", {7'd0, tx}, 8'h01);
    check("R1 core_rx", {7'd0, core_rx}, 8'h01);
    check("R1 rdata", rdata, 8'h08);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", rdata, 8'h08);

    // table: R2 core drive, R3 sample monitor, R4 forced levels, R9 return to core
    for (int i = 0; i < NVEC; i++) begin
      we = VEC[i][12]; wdata = VEC[i][11:4];
      core_tx = VEC[i][3]; samp = VEC[i][2]; bend = VEC[i][1];
      @(negedge clk);
      check($sformatf("R2 R3 R4 R9 row %0d", i), {7'd0, tx}, {7'd0, VEC[i][0]});
    end
    we = 1'b0; wdata = 8'h00; bend = 1'b0; samp = 1'b0;

    // R5 two-edge synchronizer latency, R7 normal receive path
    rx = 1'b0;
    @(negedge clk);
    check("R5 status after one edge", {7'd0, rdata[3]}, 8'h01);
    @(negedge clk);
    check("R5 status after two edges", {7'd0, rdata[3]}, 8'h00);
    check("R7 core_rx follows pin", {7'd0, core_rx}, 8'h00);

    // R6 loop-back
    write_reg(8'h01);
    core_tx = 1'b1;
    #1;
    check("R6 core_rx loops tx high", {7'd0, core_rx}, 8'h01);
    check("R6 status still external", rdata, 8'h01);
    core_tx = 1'b0;
    #1;
    check("R6 core_rx loops tx low", {7'd0, core_rx}, 8'h00);
    rx = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 status tracks pin in loop-back", rdata, 8'h09);
    check("R6 core_rx ignores pin", {7'd0, core_rx}, 8'h00);

    // R8 field read-back and reserved bits
    write_reg(8'hFF);
    check("R8 all ones write", rdata, 8'h0F);
    write_reg(8'hF8);
    check("R8 reserved and status ignored", rdata, 8'h08);
    write_reg(8'h05);
    check("R8 mixed write", rdata, 8'h0D);
    @(negedge clk);
    check("R4 dominant via readback write", {7'd0, tx}, 8'h00);

    // R7 loop-back off again
    write_reg(8'h00);
    core_tx = 1'b0;
    #1;
    check("R7 core_rx back to pin", {7'd0, core_rx}, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule